// File: doc/BRIEF.md
# Synthesizer Configuration Word Register

This block holds the setting that steers a frequency synthesizer. The setting has three fields: a 9-bit feedback divide value, a 2-bit post-divide select and a 3-bit test-mux select. The word is stored in one bank of configuration registers. Two load paths can write that bank.

The first path is a three-wire serial port. It has a shift clock, a data line and a load strobe. Fourteen bits are shifted in, most significant first. The falling edge of the load strobe then copies the shift register into the bank. The second path is a parallel port. A rising edge of its strobe copies the divide and post-divide pins straight into the bank and clears the test select. The parallel path always has priority. While its strobe is high, serial transfers are discarded.

All strobes arrive asynchronously to the system clock. Every input is passed through a two-flop synchronizer before edge detection. The block has no data stream and so no valid/ready handshake. The port edges are plain control pins and there is no back-pressure. The serial sender must space its edges by several system clocks. The parallel pins must be steady around their strobe edge. A decoded one-hot post-divide ratio is also provided for the divider that follows.

Top module: `synth_cfg_reg`

## Requirements
- R1: While reset is asserted, the block reads feedback divide 511, post-divide select 3, test select 0 and ratio 4'b1000. The shift register is cleared.
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of a 14-bit shift register. The older bits move one place toward bit 13.
- R3: A falling edge of the serial load strobe, with the parallel strobe low, copies the shift register into the bank. Bits 13..11 go to the test select, bits 10..9 to the post-divide select and bits 8..0 to the feedback divide.
- R4: A rising edge of the serial load strobe leaves the bank unchanged.
- R5: A rising edge of the parallel strobe loads the feedback divide from the 9 divide pins and the post-divide select from the 2 select pins. It clears the test select to 0.
- R6: A falling edge of the parallel strobe leaves the bank unchanged. While the strobe stays low, the parallel pins have no effect.
- R7: While the parallel strobe is high, a serial load falling edge leaves the bank unchanged.
- R8: The ratio output is one-hot with bit N set. Select 0,1,2,3 gives divide ratio 1,2,4,8, read as 4'b0001, 4'b0010, 4'b0100, 4'b1000.
- R9: A load shows at the outputs after the third rising system clock edge following the strobe change: two synchronizer stages, then the bank register.
- R10: When more than 14 bits are shifted, only the last 14 are kept.
- R11: The shift register is not changed by loads. A second serial load falling edge with no new shifts transfers the same word again. This also holds for a word shifted in while the parallel strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdat_i | input | 1 | Serial data, MSB first |
| sload_i | input | 1 | Serial load strobe; transfer on falling edge |
| pload_i | input | 1 | Parallel load strobe; capture on rising edge, priority |
| pm_i | input | 9 | Parallel feedback divide value |
| pn_i | input | 2 | Parallel post-divide select |
| fb_div_o | output | 9 | Stored feedback divide value |
| post_sel_o | output | 2 | Stored post-divide select |
| test_sel_o | output | 3 | Stored test-mux select |
| post_ratio_o | output | 4 | One-hot post-divide ratio |

## Verification
A corrupted shift register stays hidden until the next serial transfer. It then appears as a wrong field in that load, exactly three clocks after the strobe falls. For this reason every transfer is checked field by field. Transfers are also repeated without new shifts. A wrong priority or edge choice changes the bank at a strobe edge that should be ignored. The outputs are compared with a timed model on every clock, so such an error shows within three cycles.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int CFG_M_W    = 9;
  localparam int CFG_N_W    = 2;
  localparam int CFG_T_W    = 3;
  localparam int CFG_WORD_W = CFG_M_W + CFG_N_W + CFG_T_W;
  localparam int CFG_RATIO_W = 1 << CFG_N_W;

  typedef struct packed {
    logic [CFG_T_W-1:0] t;
    logic [CFG_N_W-1:0] n;
    logic [CFG_M_W-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/cfg_bit_sync.sv
module cfg_bit_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_edge_detect.sv
module cfg_edge_detect #(
  parameter int           W         = 3,
  parameter logic [W-1:0] RISE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    if (RISE_MASK[i]) begin : g_rise
      assign hit_o[i] = lvl_i[i] & ~prev_q[i];
    end else begin : g_fall
      assign hit_o[i] = ~lvl_i[i] & prev_q[i];
    end
  end
endmodule

// File: rtl/cfg_serial_shifter.sv
module cfg_serial_shifter
  import synth_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_i,
  input  logic                  bit_i,
  output logic [CFG_WORD_W-1:0] word_o
);
  logic [CFG_WORD_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[CFG_WORD_W-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import synth_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   par_hit_i,
  input  logic                   par_lvl_i,
  input  logic                   ser_hit_i,
  input  logic [CFG_M_W-1:0]     par_m_i,
  input  logic [CFG_N_W-1:0]     par_n_i,
  input  logic [CFG_WORD_W-1:0]  ser_word_i,
  output logic [CFG_M_W-1:0]     m_o,
  output logic [CFG_N_W-1:0]     n_o,
  output logic [CFG_T_W-1:0]     t_o,
  output logic [CFG_RATIO_W-1:0] ratio_o
);
  cfg_word_t cur_q, nxt;
  logic [CFG_RATIO_W-1:0] ratio_q, ratio_nxt;
  logic take;

  always_comb begin
    take = 1'b0;
    nxt  = cur_q;
    if (par_hit_i) begin
      take  = 1'b1;
      nxt.m = par_m_i;
      nxt.n = par_n_i;
      nxt.t = '0;
    end else if (ser_hit_i && !par_lvl_i) begin
      take = 1'b1;
      nxt  = cfg_word_t'(ser_word_i);
    end
  end

  always_comb begin
    for (int i = 0; i < CFG_RATIO_W; i++)
      ratio_nxt[i] = (nxt.n == CFG_N_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.m <= '1;
      cur_q.n <= '1;
      cur_q.t <= '0;
      ratio_q <= {1'b1, {(CFG_RATIO_W-1){1'b0}}};
    end else if (take) begin
      cur_q   <= nxt;
      ratio_q <= ratio_nxt;
    end
  end

  assign m_o     = cur_q.m;
  assign n_o     = cur_q.n;
  assign t_o     = cur_q.t;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk_i,
  input  logic                   sdat_i,
  input  logic                   sload_i,
  input  logic                   pload_i,
  input  logic [CFG_M_W-1:0]     pm_i,
  input  logic [CFG_N_W-1:0]     pn_i,
  output logic [CFG_M_W-1:0]     fb_div_o,
  output logic [CFG_N_W-1:0]     post_sel_o,
  output logic [CFG_T_W-1:0]     test_sel_o,
  output logic [CFG_RATIO_W-1:0] post_ratio_o
);
  localparam int LANES = 4;
  localparam int EDGES = 3;

  logic [LANES-1:0]      lvl;
  logic [EDGES-1:0]      hit;
  logic                  sclk_rise, sload_fall, pload_rise, pload_lvl, sdat_lvl;
  logic [CFG_WORD_W-1:0] shift_word;

  cfg_bit_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pload_i, sload_i, sdat_i, sclk_i}),
    .sync_o  (lvl)
  );

  assign sdat_lvl  = lvl[1];
  assign pload_lvl = lvl[3];

  cfg_edge_detect #(.W(EDGES), .RISE_MASK(3'b101)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i ({lvl[3], lvl[2], lvl[0]}),
    .hit_o (hit)
  );

  assign sclk_rise  = hit[0];
  assign sload_fall = hit[1];
  assign pload_rise = hit[2];

  cfg_serial_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (sclk_rise),
    .bit_i   (sdat_lvl),
    .word_o  (shift_word)
  );

  cfg_latch_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_hit_i  (pload_rise),
    .par_lvl_i  (pload_lvl),
    .ser_hit_i  (sload_fall),
    .par_m_i    (pm_i),
    .par_n_i    (pn_i),
    .ser_word_i (shift_word),
    .m_o        (fb_div_o),
    .n_o        (post_sel_o),
    .t_o        (test_sel_o),
    .ratio_o    (post_ratio_o)
  );
endmodule

// File: rtl/synth_cfg_reg_chk.sv
module synth_cfg_reg_chk
  import synth_cfg_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sclk_rise,
  input logic                   sload_fall,
  input logic                   pload_rise,
  input logic                   pload_lvl,
  input logic                   sdat_lvl,
  input logic [CFG_WORD_W-1:0]  shift_word,
  input logic [CFG_M_W-1:0]     pm_i,
  input logic [CFG_N_W-1:0]     pn_i,
  input logic [CFG_M_W-1:0]     fb_div_o,
  input logic [CFG_N_W-1:0]     post_sel_o,
  input logic [CFG_T_W-1:0]     test_sel_o,
  input logic [CFG_RATIO_W-1:0] post_ratio_o
);
  logic [CFG_WORD_W-1:0] bank;
  assign bank = {test_sel_o, post_sel_o, fb_div_o};

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_word == {$past(shift_word[CFG_WORD_W-2:0]), $past(sdat_lvl)});

  a_r3_serial_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (sload_fall && !pload_lvl) |=> bank == $past(shift_word));

  a_r5_par_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pload_rise |=> (fb_div_o == $past(pm_i)) && (post_sel_o == $past(pn_i)) && (test_sel_o == '0));

  a_r7_serial_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sload_fall && pload_lvl && !pload_rise) |=> $stable(bank));

  // R4 and R6: without a load event the bank holds
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pload_rise && !(sload_fall && !pload_lvl)) |=> $stable(bank));

  a_r8_ratio_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    post_ratio_o == (CFG_RATIO_W'(1) << post_sel_o));
endmodule

bind synth_cfg_reg synth_cfg_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sclk_rise    (sclk_rise),
  .sload_fall   (sload_fall),
  .pload_rise   (pload_rise),
  .pload_lvl    (pload_lvl),
  .sdat_lvl     (sdat_lvl),
  .shift_word   (shift_word),
  .pm_i         (pm_i),
  .pn_i         (pn_i),
  .fb_div_o     (fb_div_o),
  .post_sel_o   (post_sel_o),
  .test_sel_o   (test_sel_o),
  .post_ratio_o (post_ratio_o)
);

// File: tb/synth_cfg_reg_test.sv
module synth_cfg_reg_test;
  logic clk = 1'b0;
  logic rst_n, sclk, sdat, sload, pload;
  logic [8:0] pm;
  logic [1:0] pn;
  logic [8:0] fb_div;
  logic [1:0] post_sel;
  logic [2:0] test_sel;
  logic [3:0] post_ratio;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0;

  typedef struct {
    int         due;
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
  } upd_t;
  upd_t q[$];
  logic [13:0] model_sr;
  logic [8:0]  exp_m;
  logic [1:0]  exp_n;
  logic [2:0]  exp_t;

  synth_cfg_reg uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sload_i(sload),
    .pload_i(pload), .pm_i(pm), .pn_i(pn), .fb_div_o(fb_div),
    .post_sel_o(post_sel), .test_sel_o(test_sel), .post_ratio_o(post_ratio)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [3:0] ratio_of(input logic [1:0] n);
    case (n)
      2'd0: return 4'b0001;
      2'd1: return 4'b0010;
      2'd2: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  // R9: timed reference compared on every clock
  always @(negedge clk) begin
    if (started && !done) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_m = q[0].m; exp_n = q[0].n; exp_t = q[0].t;
        void'(q.pop_front());
      end
      checks++;
      if (fb_div !== exp_m || post_sel !== exp_n || test_sel !== exp_t ||
          post_ratio !== ratio_of(exp_n)) begin
        fails++;
        $display("FAIL R9 cycle %0d: got m=%0d n=%0d t=%0d r=%b, expected m=%0d n=%0d t=%0d r=%b",
                 cyc, fb_div, post_sel, test_sel, post_ratio, exp_m, exp_n, exp_t, ratio_of(exp_n));
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now(input string req, input logic [8:0] m, input logic [1:0] n,
                           input logic [2:0] t);
    checks++;
    if (fb_div !== m || post_sel !== n || test_sel !== t || post_ratio !== ratio_of(n)) begin
      fails++;
      $display("FAIL %s: got m=%0d n=%0d t=%0d r=%b, expected m=%0d n=%0d t=%0d r=%b",
               req, fb_div, post_sel, test_sel, post_ratio, m, n, t, ratio_of(n));
    end
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk); sdat = b;
    wait_n(2);
    sclk = 1'b1; model_sr = {model_sr[12:0], b};
    wait_n(4);
    sclk = 1'b0;
    wait_n(2);
  endtask

  task automatic ser_load();
    @(negedge clk); sload = 1'b1;
    wait_n(4);
    sload = 1'b0;
    if (!pload) q.push_back('{cyc + 3, model_sr[8:0], model_sr[10:9], model_sr[13:11]});
    wait_n(5);
  endtask

  task automatic ser_write(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) ser_bit(w[i]);
    ser_load();
  endtask

  task automatic par_rise(input logic [8:0] m, input logic [1:0] n);
    @(negedge clk); pm = m; pn = n;
    wait_n(2);
    pload = 1'b1;
    q.push_back('{cyc + 3, m, n, 3'd0});
    wait_n(5);
  endtask

  task automatic par_fall();
    @(negedge clk); pload = 1'b0;
    wait_n(5);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 0; sdat = 0; sload = 0; pload = 0;
    pm = '1; pn = '1; model_sr = '0;
    exp_m = 9'd511; exp_n = 2'd3; exp_t = 3'd0;
    wait_n(3);
    check_now("R1 reset", 9'd511, 2'd3, 3'd0);
    started = 1;
    rst_n = 1'b1;
    wait_n(3);
    check_now("R1 after release", 9'd511, 2'd3, 3'd0);

    // R2 R3 R8: serial word T=5 N=1 M=0x0A5
    ser_write({3'd5, 2'd1, 9'h0A5});
    check_now("R3 serial fields", 9'h0A5, 2'd1, 3'd5);
    ser_write({3'd2, 2'd0, 9'h1FE});
    check_now("R2 R8 ratio 1", 9'h1FE, 2'd0, 3'd2);

    // R4: serial load rising edge alone
    @(negedge clk); sload = 1'b1;
    wait_n(6);
    check_now("R4 sload rise ignored", 9'h1FE, 2'd0, 3'd2);
    sload = 1'b0;
    q.push_back('{cyc + 3, model_sr[8:0], model_sr[10:9], model_sr[13:11]});
    wait_n(5);

    // R10: 18 bits, last 14 kept
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1); ser_bit(1'b1);
    ser_write({3'd7, 2'd2, 9'h033});
    check_now("R10 overlong shift", 9'h033, 2'd2, 3'd7);

    // R5 R9: parallel capture with latency probe
    @(negedge clk); pm = 9'h123; pn = 2'd2;
    wait_n(2);
    pload = 1'b1;
    q.push_back('{cyc + 3, 9'h123, 2'd2, 3'd0});
    wait_n(2);
    check_now("R9 not yet at two clocks", 9'h033, 2'd2, 3'd7);
    wait_n(1);
    check_now("R9 R5 at third clock", 9'h123, 2'd2, 3'd0);
    wait_n(2);

    // R7: serial transfer while parallel strobe high
    ser_write({3'd1, 2'd1, 9'h0F0});
    check_now("R7 serial blocked", 9'h123, 2'd2, 3'd0);

    // R6: falling edge of parallel strobe, pins changing while low
    par_fall();
    @(negedge clk); pm = 9'h0AA; pn = 2'd0;
    wait_n(6);
    check_now("R6 pload low no effect", 9'h123, 2'd2, 3'd0);

    // R11: reload same shift contents without shifting
    ser_load();
    check_now("R11 retransfer", 9'h0F0, 2'd1, 3'd1);

    // R8: select 3 via parallel path
    par_rise(9'h001, 2'd3);
    check_now("R8 R5 ratio 8", 9'h001, 2'd3, 3'd0);
    par_fall();
    ser_load();
    check_now("R11 second retransfer", 9'h0F0, 2'd1, 3'd1);

    wait_n(4);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule